// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide flash host bus and a separate program/erase engine. It watches completed host write cycles and looks for fixed multi-cycle unlock sequences. Every command opens with two key writes to fixed addresses. A third write selects one of four things: a single-byte program, a longer erase-or-lock family, entry into identification mode, or exit from identification mode. When a sequence completes, the block sends a one-cycle start request to the engine, or it updates one of its two mode flags.

The decoder holds two flags. The identification-mode flag redirects reads to a small table of constant codes and a lock-status byte. The boot-lock flag marks the lowest region of the array as protected. No command clears the boot-lock flag; only the block reset clears it. While the engine reports busy, host writes are dropped entirely. The read path is a combinational multiplexer between the array data and the identification table.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, prog_start and erase_start are low, id_mode and boot_locked are 0, and rd_data equals array_rdata.
- R2: The writes AA@5555, 55@2AAA and A0@5555, followed by a fourth write of D@A, pulse prog_start high for one cycle with prog_addr=A (full width) and prog_data=D. The pulse is visible in the second clock cycle after the data strobe.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 10@5555 pulse erase_start for one cycle. This also happens when boot_locked is 1.
- R4: The same five-write prefix as R3, followed by 40@5555, sets boot_locked to 1. Once set, it stays 1 for every later write until reset.
- R5: The prefix AA@5555, 55@2AAA followed by 90@5555 sets id_mode to 1. In that mode, rd_addr 0 reads 0x1F, rd_addr 1 reads 0x13, and any rd_addr of 3 or above reads 0x00. With id_mode at 0, rd_data equals array_rdata.
- R6: In identification mode, rd_addr 2 reads 0x00 when boot_locked is 0 and 0x01 when boot_locked is 1.
- R7: Either of two writes clears id_mode: the three-write sequence ending in F0@5555, or a single F0 written to any address. An F0 that arrives as the data byte of a program command starts the program and leaves id_mode unchanged.
- R8: Command addresses are compared on bus_addr bits 14..0 only. Higher address bits do not affect decoding.
- R9: A write that does not match the expected next step returns the decoder to idle. For example, after AA@5555 a write of 12@2AAA, the later writes A0@5555 and a data write start no program.
- R10: A mismatching write of AA@5555 restarts the sequence at its first step. Thus AA, 55, AA, 55, A0 followed by a data write starts a program.
- R11: A write (address or data strobe) arriving while engine_busy is 1 is ignored. It neither advances nor resets the decoder and does not change id_mode.
- R12: While boot_locked is 1, a program command whose target address is below 0x4000 issues no prog_start. A target of 0x4000 or above still does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_stb | input | 1 | One-cycle pulse that latches bus_addr at the start of a write |
| bus_addr | input | 19 | Host write address |
| data_stb | input | 1 | One-cycle pulse that latches bus_data and completes the write |
| bus_data | input | 8 | Host write data |
| engine_busy | input | 1 | Program/erase engine is working |
| rd_addr | input | 19 | Host read address |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data returned to the host |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_start | output | 1 | One-cycle chip-erase request |
| id_mode | output | 1 | Identification mode is active |
| boot_locked | output | 1 | Boot region is protected |

## Verification
The hardest case to reach is a write that lands while the engine is busy in the middle of an unlock sequence. A dropped write and a mismatching write look the same at the ports until a later write decides whether a command still completes. The stimulus opens a program sequence, raises busy around the second key write, then repeats that key write and finishes the command. A program request appears only if the busy-time write left the decoder untouched. The boot-lock read-back and the protected-program refusal need the irreversible lock flag, so they run after the lock command and before the final reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] KEY_ADDR1 = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR2 = 15'h2AAA;

  localparam logic [BYTE_W-1:0] KEY_BYTE1  = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_BYTE2  = 8'h55;
  localparam logic [BYTE_W-1:0] OP_PROGRAM = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_EXTEND  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_ID_IN   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ID_OUT  = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h10;
  localparam logic [BYTE_W-1:0] OP_LOCK    = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PGM,
    ST_EXT0,
    ST_EXT1,
    ST_EXT2
  } seq_state_t;
endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              data_stb,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              engine_busy,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [BYTE_W-1:0] ev_data
);
  logic              addr_en;
  logic              data_en;
  logic [ADDR_W-1:0] addr_q;
  logic              ev_valid_q;
  logic [ADDR_W-1:0] ev_addr_q;
  logic [BYTE_W-1:0] ev_data_q;

  // Busy drops both halves of a host write.
  assign addr_en = addr_stb & ~engine_busy;
  assign data_en = data_stb & ~engine_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid_q <= 1'b0;
    end else begin
      ev_valid_q <= data_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_addr_q <= '0;
      ev_data_q <= '0;
    end else if (data_en) begin
      ev_addr_q <= addr_q;
      ev_data_q <= bus_data;
    end
  end

  assign ev_valid = ev_valid_q;
  assign ev_addr  = ev_addr_q;
  assign ev_data  = ev_data_q;
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int BOOT_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [BYTE_W-1:0] ev_data,
  input  logic              boot_locked,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data,
  output logic              erase_start,
  output logic              set_id,
  output logic              clr_id,
  output logic              set_lock
);
  localparam logic [ADDR_W-1:0] BOOT_LIMIT = ADDR_W'(BOOT_BYTES);

  seq_state_t        state_q, state_n;
  logic [CMD_AW-1:0] cmd_addr;
  logic              at_key1;
  logic              hit_key1;
  logic              hit_key2;
  logic              restart_or_idle_key1;
  logic              in_boot;
  logic              prog_fire;
  logic              erase_fire;
  logic              prog_start_q;
  logic              erase_start_q;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [BYTE_W-1:0] prog_data_q;

  // Only the low address bits take part in command decoding.
  assign cmd_addr = ev_addr[CMD_AW-1:0];
  assign at_key1  = (cmd_addr == KEY_ADDR1);
  assign hit_key1 = at_key1 && (ev_data == KEY_BYTE1);
  assign hit_key2 = (cmd_addr == KEY_ADDR2) && (ev_data == KEY_BYTE2);
  assign restart_or_idle_key1 = hit_key1;
  assign in_boot  = (ev_addr < BOOT_LIMIT);

  always_comb begin
    state_n    = state_q;
    prog_fire  = 1'b0;
    erase_fire = 1'b0;
    set_id     = 1'b0;
    set_lock   = 1'b0;
    if (ev_valid) begin
      case (state_q)
        ST_IDLE: state_n = hit_key1 ? ST_KEY1 : ST_IDLE;
        ST_KEY1: begin
          if (hit_key2)                  state_n = ST_KEY2;
          else if (restart_or_idle_key1) state_n = ST_KEY1;
          else                           state_n = ST_IDLE;
        end
        ST_KEY2: begin
          if (at_key1 && ev_data == OP_PROGRAM) begin
            state_n = ST_PGM;
          end else if (at_key1 && ev_data == OP_EXTEND) begin
            state_n = ST_EXT0;
          end else if (at_key1 && ev_data == OP_ID_IN) begin
            set_id  = 1'b1;
            state_n = ST_IDLE;
          end else if (restart_or_idle_key1) begin
            state_n = ST_KEY1;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_PGM: begin
          prog_fire = !(boot_locked && in_boot);
          state_n   = ST_IDLE;
        end
        ST_EXT0: state_n = hit_key1 ? ST_EXT1 : ST_IDLE;
        ST_EXT1: begin
          if (hit_key2)                  state_n = ST_EXT2;
          else if (restart_or_idle_key1) state_n = ST_KEY1;
          else                           state_n = ST_IDLE;
        end
        ST_EXT2: begin
          state_n = ST_IDLE;
          if (at_key1 && ev_data == OP_ERASE) begin
            erase_fire = 1'b1;
          end else if (at_key1 && ev_data == OP_LOCK) begin
            set_lock = 1'b1;
          end else if (restart_or_idle_key1) begin
            state_n = ST_KEY1;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // Any F0 leaves identification mode, except a program data byte.
  assign clr_id = ev_valid && (ev_data == OP_ID_OUT) && (state_q != ST_PGM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start_q  <= 1'b0;
      erase_start_q <= 1'b0;
    end else begin
      prog_start_q  <= prog_fire;
      erase_start_q <= erase_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else if (prog_fire) begin
      prog_addr_q <= ev_addr;
      prog_data_q <= ev_data;
    end
  end

  assign prog_start  = prog_start_q;
  assign erase_start = erase_start_q;
  assign prog_addr   = prog_addr_q;
  assign prog_data   = prog_data_q;
endmodule

// File: rtl/flash_mode_regs.sv
module flash_mode_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic set_id,
  input  logic clr_id,
  input  logic set_lock,
  output logic id_mode,
  output logic boot_locked
);
  logic id_q;
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= 1'b0;
    end else if (set_id || clr_id) begin
      id_q <= set_id;
    end
  end

  // Sticky: only the reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (set_lock) begin
      lock_q <= 1'b1;
    end
  end

  assign id_mode     = id_q;
  assign boot_locked = lock_q;
endmodule

// File: rtl/flash_id_readmux.sv
module flash_id_readmux
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W   = 19,
  parameter logic [BYTE_W-1:0] MFR_CODE = 8'h1F,
  parameter logic [BYTE_W-1:0] DEV_CODE = 8'h13
) (
  input  logic              id_mode,
  input  logic              boot_locked,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] array_rdata,
  output logic [BYTE_W-1:0] rd_data
);
  always_comb begin
    if (!id_mode) begin
      rd_data = array_rdata;
    end else if (rd_addr == ADDR_W'(0)) begin
      rd_data = MFR_CODE;
    end else if (rd_addr == ADDR_W'(1)) begin
      rd_data = DEV_CODE;
    end else if (rd_addr == ADDR_W'(2)) begin
      rd_data = {{(BYTE_W-1){1'b0}}, boot_locked};
    end else begin
      rd_data = '0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W     = 19,
  parameter int                BOOT_BYTES = 16384,
  parameter logic [BYTE_W-1:0] MFR_CODE   = 8'h1F,
  parameter logic [BYTE_W-1:0] DEV_CODE   = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              data_stb,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              engine_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] array_rdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data,
  output logic              erase_start,
  output logic              id_mode,
  output logic              boot_locked
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              ev_valid;
  logic [ADDR_W-1:0] ev_addr;
  logic [BYTE_W-1:0] ev_data;
  logic              set_id;
  logic              clr_id;
  logic              set_lock;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  flash_bus_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .addr_stb    (addr_stb),
    .bus_addr    (bus_addr),
    .data_stb    (data_stb),
    .bus_data    (bus_data),
    .engine_busy (engine_busy),
    .ev_valid    (ev_valid),
    .ev_addr     (ev_addr),
    .ev_data     (ev_data)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ev_valid    (ev_valid),
    .ev_addr     (ev_addr),
    .ev_data     (ev_data),
    .boot_locked (boot_locked),
    .prog_start  (prog_start),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data),
    .erase_start (erase_start),
    .set_id      (set_id),
    .clr_id      (clr_id),
    .set_lock    (set_lock)
  );

  flash_mode_regs u_modes (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .set_id      (set_id),
    .clr_id      (clr_id),
    .set_lock    (set_lock),
    .id_mode     (id_mode),
    .boot_locked (boot_locked)
  );

  flash_id_readmux #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_readmux (
    .id_mode     (id_mode),
    .boot_locked (boot_locked),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int         ADDR_W     = 19,
  parameter int         BOOT_BYTES = 16384,
  parameter logic [7:0] MFR_CODE   = 8'h1F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_stb,
  input logic              engine_busy,
  input logic              ev_valid,
  input logic              prog_start,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              erase_start,
  input logic              id_mode,
  input logic              boot_locked,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [7:0]        array_rdata
);
  localparam logic [ADDR_W-1:0] BOOT_LIMIT = ADDR_W'(BOOT_BYTES);

  p_one_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start}));

  p_prog_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  p_prog_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(ev_valid));

  p_erase_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_locked |=> boot_locked);

  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (rd_data == array_rdata));

  p_mfr_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == ADDR_W'(0)) |-> (rd_data == MFR_CODE));

  p_lock_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == ADDR_W'(2)) |-> (rd_data[0] == boot_locked));

  p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && engine_busy) |=> !ev_valid);

  p_boot_guard_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start && boot_locked) |-> (prog_addr >= BOOT_LIMIT));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BOOT_BYTES (BOOT_BYTES),
  .MFR_CODE   (MFR_CODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .data_stb    (data_stb),
  .engine_busy (engine_busy),
  .ev_valid    (ev_valid),
  .prog_start  (prog_start),
  .prog_addr   (prog_addr),
  .erase_start (erase_start),
  .id_mode     (id_mode),
  .boot_locked (boot_locked),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .array_rdata (array_rdata)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 44;

  logic        clk;
  logic        rst_n;
  logic        addr_stb;
  logic [18:0] bus_addr;
  logic        data_stb;
  logic [7:0]  bus_data;
  logic        engine_busy;
  logic [18:0] rd_addr;
  logic [7:0]  array_rdata;
  logic [7:0]  rd_data;
  logic        prog_start;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data;
  logic        erase_start;
  logic        id_mode;
  logic        boot_locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .bus_addr(bus_addr),
    .data_stb(data_stb), .bus_data(bus_data), .engine_busy(engine_busy),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .id_mode(id_mode), .boot_locked(boot_locked)
  );

  // Array model: data depends only on the read address.
  assign array_rdata = rd_addr[7:0] ^ 8'h5A;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Entry: {req, addr, data, exp_prog, exp_erase, exp_id, exp_lock}
  localparam logic [34:0] VEC [0:NVEC-1] = '{
    {4'd2,  19'h05555, 8'hAA, 4'b0000},  // R2 program
    {4'd2,  19'h02AAA, 8'h55, 4'b0000},
    {4'd2,  19'h05555, 8'hA0, 4'b0000},
    {4'd2,  19'h01234, 8'h12, 4'b1000},
    {4'd3,  19'h05555, 8'hAA, 4'b0000},  // R3 erase
    {4'd3,  19'h02AAA, 8'h55, 4'b0000},
    {4'd3,  19'h05555, 8'h80, 4'b0000},
    {4'd3,  19'h05555, 8'hAA, 4'b0000},
    {4'd3,  19'h02AAA, 8'h55, 4'b0000},
    {4'd3,  19'h05555, 8'h10, 4'b0100},
    {4'd8,  19'h45555, 8'hAA, 4'b0000},  // R8 upper bits ignored
    {4'd8,  19'h7AAAA, 8'h55, 4'b0000},
    {4'd8,  19'h35555, 8'h90, 4'b0010},
    {4'd7,  19'h05555, 8'hAA, 4'b0010},  // R7 three-write exit
    {4'd7,  19'h02AAA, 8'h55, 4'b0010},
    {4'd7,  19'h05555, 8'hF0, 4'b0000},
    {4'd5,  19'h05555, 8'hAA, 4'b0000},  // R5 entry, R7 single exit
    {4'd5,  19'h02AAA, 8'h55, 4'b0000},
    {4'd5,  19'h05555, 8'h90, 4'b0010},
    {4'd7,  19'h12345, 8'hF0, 4'b0000},
    {4'd9,  19'h05555, 8'hAA, 4'b0000},  // R9 mismatch to idle
    {4'd9,  19'h02AAA, 8'h12, 4'b0000},
    {4'd9,  19'h05555, 8'hA0, 4'b0000},
    {4'd9,  19'h00100, 8'h77, 4'b0000},
    {4'd10, 19'h05555, 8'hAA, 4'b0000},  // R10 restart
    {4'd10, 19'h02AAA, 8'h55, 4'b0000},
    {4'd10, 19'h05555, 8'hAA, 4'b0000},
    {4'd10, 19'h02AAA, 8'h55, 4'b0000},
    {4'd10, 19'h05555, 8'hA0, 4'b0000},
    {4'd7,  19'h06000, 8'hF0, 4'b1000},  // R7 F0 as program data
    {4'd4,  19'h05555, 8'hAA, 4'b0000},  // R4 lock
    {4'd4,  19'h02AAA, 8'h55, 4'b0000},
    {4'd4,  19'h05555, 8'h80, 4'b0000},
    {4'd4,  19'h05555, 8'hAA, 4'b0000},
    {4'd4,  19'h02AAA, 8'h55, 4'b0000},
    {4'd4,  19'h05555, 8'h40, 4'b0001},
    {4'd12, 19'h05555, 8'hAA, 4'b0001},  // R12 boot target refused
    {4'd12, 19'h02AAA, 8'h55, 4'b0001},
    {4'd12, 19'h05555, 8'hA0, 4'b0001},
    {4'd12, 19'h00100, 8'h5A, 4'b0001},
    {4'd12, 19'h05555, 8'hAA, 4'b0001},  // R12 first byte above boot
    {4'd12, 19'h02AAA, 8'h55, 4'b0001},
    {4'd12, 19'h05555, 8'hA0, 4'b0001},
    {4'd12, 19'h04000, 8'hC3, 4'b1001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); addr_stb = 1'b1; bus_addr = a;
    @(negedge clk); addr_stb = 1'b0; data_stb = 1'b1; bus_data = d;
    @(negedge clk); data_stb = 1'b0;
  endtask

  task automatic wr_chk(input logic [18:0] a, input logic [7:0] d);
    wr(a, d);
    @(negedge clk);
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    addr_stb = 1'b0; data_stb = 1'b0; bus_addr = '0; bus_data = '0;
    engine_busy = 1'b0; rd_addr = 19'h00077;
    do_reset();

    // R1 reset state
    chk("R1 prog_start", 32'(prog_start), 0);
    chk("R1 erase_start", 32'(erase_start), 0);
    chk("R1 id_mode", 32'(id_mode), 0);
    chk("R1 boot_locked", 32'(boot_locked), 0);
    rd(19'h00077, 8'h77 ^ 8'h5A, "R1 rd_data passthrough");

    // R6 unlocked read-back
    wr_chk(19'h05555, 8'hAA); wr_chk(19'h02AAA, 8'h55); wr_chk(19'h05555, 8'h90);
    chk("R5 id entry", 32'(id_mode), 1);
    rd(19'h00002, 8'h00, "R6 lock byte unlocked");
    rd(19'h00000, 8'h1F, "R5 mfr code");
    wr_chk(19'h00000, 8'hF0);
    chk("R7 single F0 exit", 32'(id_mode), 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [3:0]  req;
      logic [18:0] va;
      logic [7:0]  vd;
      req = VEC[k][34:31];
      va  = VEC[k][30:12];
      vd  = VEC[k][11:4];
      wr(va, vd);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d prog_start", req, k), 32'(prog_start), 32'(VEC[k][3]));
      chk($sformatf("R%0d vec%0d erase_start", req, k), 32'(erase_start), 32'(VEC[k][2]));
      chk($sformatf("R%0d vec%0d id_mode", req, k), 32'(id_mode), 32'(VEC[k][1]));
      chk($sformatf("R%0d vec%0d boot_locked", req, k), 32'(boot_locked), 32'(VEC[k][0]));
      if (VEC[k][3]) begin
        chk($sformatf("R%0d vec%0d prog_addr", req, k), 32'(prog_addr), 32'(va));
        chk($sformatf("R%0d vec%0d prog_data", req, k), 32'(prog_data), 32'(vd));
      end
    end

    // R6 locked read-back and R5 table
    wr_chk(19'h05555, 8'hAA); wr_chk(19'h02AAA, 8'h55); wr_chk(19'h05555, 8'h90);
    rd(19'h00002, 8'h01, "R6 lock byte locked");
    rd(19'h00000, 8'h1F, "R5 mfr code");
    rd(19'h00001, 8'h13, "R5 dev code");
    rd(19'h00005, 8'h00, "R5 other id address");

    // R11 busy F0 ignored
    @(negedge clk); engine_busy = 1'b1;
    wr_chk(19'h00000, 8'hF0);
    chk("R11 busy F0 keeps id_mode", 32'(id_mode), 1);
    engine_busy = 1'b0;
    wr_chk(19'h00000, 8'hF0);
    chk("R7 F0 exit after busy", 32'(id_mode), 0);
    rd(19'h00007, 8'h07 ^ 8'h5A, "R5 passthrough after exit");

    // R11 busy write mid-sequence neither advances nor resets
    wr_chk(19'h05555, 8'hAA);
    @(negedge clk); engine_busy = 1'b1;
    wr_chk(19'h02AAA, 8'h55);
    engine_busy = 1'b0;
    wr_chk(19'h02AAA, 8'h55);
    wr_chk(19'h05555, 8'hA0);
    wr(19'h10000, 8'h66);
    @(negedge clk);
    chk("R11 program after busy write", 32'(prog_start), 1);
    chk("R11 prog_addr", 32'(prog_addr), 32'h10000);

    // R3 erase still issued while locked
    wr_chk(19'h05555, 8'hAA); wr_chk(19'h02AAA, 8'h55); wr_chk(19'h05555, 8'h80);
    wr_chk(19'h05555, 8'hAA); wr_chk(19'h02AAA, 8'h55);
    wr(19'h05555, 8'h10);
    @(negedge clk);
    chk("R3 erase while locked", 32'(erase_start), 1);
    @(negedge clk);
    chk("R3 erase pulse ends", 32'(erase_start), 0);

    // R1 reset clears flags
    do_reset();
    chk("R1 lock cleared by reset", 32'(boot_locked), 0);
    chk("R1 id cleared by reset", 32'(id_mode), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule